// File: doc/BRIEF.md
# Framed Serial DAC Input Register

This block is the digital front end of a serially loaded 12-bit voltage DAC. A host sends 16-bit frames on three wires: an active-low frame select, a serial clock and serial data. The block samples all three wires in its own system clock domain. Data is taken on each falling serial-clock edge while the frame is open. On the 16th falling edge the block copies the data code and the power-down selection into a holding register, and that register drives the converter.

A frame that is closed early is thrown away, and the holding register keeps its old contents. After reset the converter sees code zero in normal mode. It keeps that value until the first complete frame arrives. Extra clock edges after the 16th are ignored until the frame select goes high again. Each load raises a one-cycle strobe.

Top module: `dac_frame_rx`

## Requirements
- R1: While reset is applied and after it is released, `dac_code` is 0, `pd_mode` is 0 and `load_stb` is 0. These values stay until the first complete frame.
- R2: A frame opens when the synchronized `frm_n` is low. One data bit is taken from `sdi` at each falling edge of `sck`. The first bit taken is frame bit 15, so the frame is sent most significant bit first.
- R3: On the 16th falling edge of an open frame, `dac_code` loads frame bits 11:0 and `pd_mode` loads frame bits 13:12. Frame bits 15:14 have no effect. `pd_mode` codes: 00 is normal operation; 01, 10 and 11 each select a low-power output termination and are passed out unchanged.
- R4: `load_stb` is high for exactly one cycle, in the same cycle in which `dac_code` and `pd_mode` take their new values. The outputs never change in any other cycle.
- R5: If `frm_n` goes high after fewer than 16 falling edges, the partial frame is discarded. No load occurs and the outputs keep their values.
- R6: Falling edges after the 16th, while `frm_n` stays low, are ignored. A new frame starts only after `frm_n` has been seen high and then low again.
- R7: If a high `frm_n` and the 16th falling `sck` edge are sampled in the same system-clock cycle, the frame is cancelled and no load occurs.
- R8: Each input passes through two synchronizer flops. The load becomes visible after the second rising `clk` edge that follows the first edge at which `sck` is sampled low. `sck` must stay high for at least two `clk` cycles and low for at least two `clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_n | input | 1 | Active-low frame select (asynchronous) |
| sck | input | 1 | Serial clock; data taken on its falling edge (asynchronous) |
| sdi | input | 1 | Serial data, MSB first (asynchronous) |
| dac_code | output | 12 | Held converter code |
| pd_mode | output | 2 | Held power-down selection |
| load_stb | output | 1 | One-cycle pulse when the holding register loads |

## Verification
The 16th falling edge of `sck` can reach the logic in the same cycle as the rising edge of `frm_n`. In that cycle a load and an abort compete. The bench provokes this by lowering `sck` and raising `frm_n` at the same instant, so both pass through identical synchronizer paths and arrive together. It then checks that no strobe fires and that the held code and mode are unchanged. A behavioural reference model gives the same cancel-first verdict and is compared with the outputs on every clock.

// File: rtl/dac_frame_rx.sv
module dac_frame_rx #(
  parameter int DW = 12,
  parameter int PW = 2,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_n,
  input  logic          sck,
  input  logic          sdi,
  output logic [DW-1:0] dac_code,
  output logic [PW-1:0] pd_mode,
  output logic          load_stb
);
  localparam int SW = DW + PW - 1;
  localparam int CW = $clog2(FW);
  localparam logic [CW-1:0] LAST = CW'(FW - 1);

  logic [1:0] syn_q, sck_q, din_q;
  logic       sck_d;
  logic       syn_s, sck_fall, din_s;
  logic [SW-1:0] sh;
  logic [CW-1:0] bit_cnt;
  logic          done;

  assign syn_s    = syn_q[1];
  assign din_s    = din_q[1];
  assign sck_fall = sck_d & ~sck_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syn_q <= 2'b11;
      sck_q <= 2'b00;
      din_q <= 2'b00;
      sck_d <= 1'b0;
    end else begin
      syn_q <= {syn_q[0], frm_n};
      sck_q <= {sck_q[0], sck};
      din_q <= {din_q[0], sdi};
      sck_d <= sck_q[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh       <= '0;
      bit_cnt  <= '0;
      done     <= 1'b0;
      dac_code <= '0;
      pd_mode  <= '0;
      load_stb <= 1'b0;
    end else begin
      load_stb <= 1'b0;
      if (syn_s) begin
        bit_cnt <= '0;
        done    <= 1'b0;
      end else if (!done && sck_fall) begin
        sh <= {sh[SW-2:0], din_s};
        if (bit_cnt == LAST) begin
          dac_code <= {sh[DW-2:0], din_s};
          pd_mode  <= sh[SW-1:DW-1];
          load_stb <= 1'b1;
          done     <= 1'b1;
          bit_cnt  <= '0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dac_frame_rx_chk.sv
module dac_frame_rx_chk #(
  parameter int DW = 12,
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] dac_code,
  input logic [PW-1:0] pd_mode,
  input logic          load_stb,
  input logic          syn_s
);
  AST_CODE_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> load_stb); // R4
  AST_MODE_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd_mode) |-> load_stb); // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb); // R4
  AST_NO_LOAD_ON_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> !$past(syn_s)); // R7
  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |=> (dac_code == '0 && pd_mode == '0 && !load_stb)); // R1
endmodule

bind dac_frame_rx dac_frame_rx_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dac_code(dac_code), .pd_mode(pd_mode),
  .load_stb(load_stb), .syn_s(syn_s)
);

// File: tb/dac_frame_rx_test.sv
`timescale 1ns/1ps
module dac_frame_rx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [11:0] dac_code;
  logic [1:0]  pd_mode;
  logic        load_stb;

  int n_cmp = 0, n_bad = 0, n_stb = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dac_frame_rx uut (.clk(clk), .rst_n(rst_n), .frm_n(frm_n), .sck(sck), .sdi(sdi),
                    .dac_code(dac_code), .pd_mode(pd_mode), .load_stb(load_stb));

  // behavioural reference model
  bit [2:0] hist[$];
  int m_cnt, m_word;
  bit m_done;
  int m_code, m_pd;
  bit m_stb;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {3'b100, 3'b100, 3'b100};
      m_cnt = 0; m_word = 0; m_done = 0; m_code = 0; m_pd = 0; m_stb = 0;
    end else begin
      bit [2:0] cur, prv;
      prv = hist[0]; cur = hist[1];
      m_stb = 0;
      if (cur[2]) begin
        m_cnt = 0; m_done = 0;
      end else if (!m_done && prv[1] && !cur[1]) begin
        m_word = ((m_word << 1) | cur[0]) & 16'hFFFF;
        m_cnt++;
        if (m_cnt == 16) begin
          m_code = m_word % 4096;
          m_pd = (m_word / 4096) % 4;
          m_stb = 1; m_done = 1; m_cnt = 0;
        end
      end
      void'(hist.pop_front());
      hist.push_back({frm_n, sck, sdi});
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (load_stb) n_stb++;
    chk("R4 model code", dac_code, m_code);
    chk("R3 model mode", pd_mode, m_pd);
    chk("R4 model strobe", load_stb, m_stb);
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(bit [15:0] w, int nbits, bit cancel_on_last);
    frm_n = 1'b0; wait_n(3);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b1; sdi = w[15 - i]; wait_n(3);
      sck = 1'b0;
      if (cancel_on_last && i == nbits - 1) frm_n = 1'b1;
      wait_n(3);
    end
    frm_n = 1'b1; wait_n(4);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int s0;
    wait_n(4);
    chk("R1 reset code", dac_code, 0);
    chk("R1 reset mode", pd_mode, 0);
    chk("R1 reset strobe", load_stb, 0);
    rst_n = 1'b1; wait_n(10);
    chk("R1 code stays zero", dac_code, 0);

    send(16'h0000 | 16'h2ABC, 16, 0);
    chk("R3 code", dac_code, 'hABC);
    chk("R3 mode 10", pd_mode, 2);
    chk("R2 msb first", dac_code[11], 1);

    s0 = n_stb;
    send(16'hD123, 16, 0);
    chk("R3 dont-care bits", dac_code, 'h123);
    chk("R3 mode 01", pd_mode, 1);
    chk("R4 one strobe per frame", n_stb - s0, 1);

    send(16'h3FFF, 10, 0);
    chk("R5 abort keeps code", dac_code, 'h123);
    chk("R5 abort keeps mode", pd_mode, 1);

    // R6: extra edges after the 16th, then another 16 with frame still open
    frm_n = 1'b0; wait_n(3);
    for (int i = 0; i < 36; i++) begin
      bit [15:0] w = 16'h3456;
      sck = 1'b1; sdi = (i < 16) ? w[15 - i] : 1'b1; wait_n(3);
      sck = 1'b0; wait_n(3);
    end
    chk("R6 later edges ignored code", dac_code, 'h456);
    chk("R6 later edges ignored mode", pd_mode, 3);
    frm_n = 1'b1; wait_n(4);

    // R7: sync rise with 16th falling edge
    s0 = n_stb;
    send(16'h0F0F, 16, 1);
    chk("R7 cancel wins code", dac_code, 'h456);
    chk("R7 no strobe", n_stb - s0, 0);

    // R8: latency of the load after the 16th fall
    frm_n = 1'b0; wait_n(3);
    for (int i = 0; i < 16; i++) begin
      bit [15:0] w = 16'h0A5A;
      sck = 1'b1; sdi = w[15 - i]; wait_n(3);
      sck = 1'b0;
      if (i < 15) wait_n(3);
    end
    wait_n(2);
    chk("R8 not yet loaded", load_stb, 0);
    chk("R8 old code", dac_code, 'h456);
    wait_n(1);
    chk("R8 strobe at latency", load_stb, 1);
    chk("R8 new code", dac_code, 'hA5A);
    chk("R3 mode 00", pd_mode, 0);
    wait_n(2);
    frm_n = 1'b1; wait_n(4);

    send(16'h0001, 16, 0);
    chk("R2 lsb last", dac_code, 1);
    wait_n(5);
    finish_run();
  end
endmodule